// File: doc/BRIEF.md
# Register-Update Strobe Generator

This block produces the single-cycle strobe that copies staged configuration registers into their active copies. The strobe has two sources, selected by a mode input. In external mode, a host drives a bidirectional update pad. The block synchronizes the pad to the system clock and turns each rising edge into one strobe. In internal mode, a free-running down counter behind a power-of-two prescaler produces the strobe at a fixed period. The block then turns the pad into an output that pulses with every strobe, so the host can see when each update happened.

The mode, prescale code and reload value are plain control inputs that are sampled every cycle. The strobe and the pad drive are plain outputs with no handshake. A consumer acts on the strobe in the cycle it is high and cannot stall it, so no back-pressure exists at any edge of the block. Changing the mode or the prescale code restarts the timing chain. The first internal interval after such a change is therefore always full length.

Top module: `upd_strobe_gen`

## Requirements
- R1: While reset is asserted and after it is released, `update_o`, `pad_o` and `pad_oe_o` are 0 and the block is in external mode.
- R2: With `mode_int_i` = 0, each 0-to-1 transition of `pad_i` gives exactly one `update_o` pulse of one cycle. The pulse is visible after the third rising clock edge following the pad change. A pad held high gives no further pulses.
- R3: With `mode_int_i` = 0, `pad_oe_o` and `pad_o` stay 0, and the value of `prescale_i` has no effect on the timing of external strobes.
- R4: `pad_oe_o` becomes 1 one clock edge after `mode_int_i` is sampled as 1, and becomes 0 one edge after it is sampled as 0.
- R5: The prescale code sets the counter tick divisor D: code 2'b00 gives D = 1, 2'b01 gives D = 2, 2'b10 gives D = 4 and 2'b11 gives D = 8.
- R6: In internal mode with reload value R, successive `update_o` pulses are (R+1)*D cycles apart. With R = 0, this means one pulse every D cycles.
- R7: In internal mode, `pad_o` is 1 exactly in the cycles where `update_o` is 1 and is 0 otherwise.
- R8: A change of `mode_int_i` or of `prescale_i` clears the prescaler and reloads the counter. The first internal pulse after such a change is seen after rising edge number 1+(R+1)*D, counting the first edge after the change as edge 1.
- R9: In internal mode, transitions on `pad_i` produce no `update_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_int_i | input | 1 | 0 = strobe comes from the pad, 1 = strobe comes from the internal counter |
| prescale_i | input | 2 | Tick divisor code (1, 2, 4 or 8) |
| reload_i | input | CNT_W | Value loaded into the down counter after each strobe and on restart |
| pad_i | input | 1 | Input value sampled from the update pad |
| pad_o | output | 1 | Value driven onto the update pad in internal mode |
| pad_oe_o | output | 1 | Pad output enable, high in internal mode |
| update_o | output | 1 | One-cycle register-update strobe |

## Verification
Two functions can fall in the same cycle: a counter expiry and a restart caused by a change of the prescale code. They collide when the code is changed while an interval is partly through. The bench changes the code part-way through an interval and checks two things. No strobe may come from the stale interval, and the next strobe must arrive a full new interval after the change. The bench also toggles the pad during internal mode, and changes the prescale code while in external mode before a pad edge. In both cases it checks that the mode that is not selected does not affect the strobe timing.

// File: rtl/upd_pkg.sv
package upd_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] ps_code_t;
  typedef enum logic {SRC_PAD = 1'b0, SRC_TIMER = 1'b1} upd_src_e;
endpackage

// File: rtl/upd_pin_sync.sv
module upd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pad_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R2: an edge detector never reports two rises back to back
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/upd_prescaler.sv
module upd_prescaler
  import upd_pkg::*;
#(
  parameter int PS_W = (1 << CODE_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            clr_i,
  input  ps_code_t        code_i,
  output logic            tick_o,
  output logic [PS_W-1:0] cnt_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] last_cnt;

  always_comb begin
    last_cnt = PS_W'({PS_W{1'b1}} >> (PS_W - int'(code_i)));
  end

  assign tick_o = en_i && !clr_i && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5: the prescale count never passes the divisor chosen by the code
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && $stable(code_i)) |-> (cnt_q <= last_cnt));
endmodule

// File: rtl/upd_down_counter.sv
module upd_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_i)  cnt_q <= reload_i;
    else if (fire_o)  cnt_q <= reload_i;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6: an expiry reloads the counter from the programmed value
  a_r6_reload_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/upd_strobe_gen.sv
module upd_strobe_gen
  import upd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_int_i,
  input  logic [1:0]       prescale_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic             update_o
);
  localparam int PS_W = (1 << CODE_W) - 1;

  upd_src_e         src_q;
  ps_code_t         code_q;
  logic             restart;
  logic             tick;
  logic             ext_rise;
  logic             int_fire;
  logic             strobe_q;
  logic [PS_W-1:0]  ps_cnt;
  logic [CNT_W-1:0] dc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_PAD;
      code_q <= '0;
    end else begin
      src_q  <= upd_src_e'(mode_int_i);
      code_q <= prescale_i;
    end
  end

  assign restart = (mode_int_i != logic'(src_q)) || (prescale_i != code_q);

  upd_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pad_i),
    .rise_o (ext_rise)
  );

  upd_prescaler #(.PS_W(PS_W)) ps_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (src_q == SRC_TIMER),
    .clr_i  (restart),
    .code_i (code_q),
    .tick_o (tick),
    .cnt_o  (ps_cnt)
  );

  upd_down_counter #(.CNT_W(CNT_W)) dc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (restart),
    .tick_i   (tick),
    .reload_i (reload_i),
    .fire_o   (int_fire),
    .cnt_o    (dc_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= (src_q == SRC_TIMER) ? int_fire : ext_rise;
  end

  assign update_o = strobe_q;
  assign pad_oe_o = (src_q == SRC_TIMER);
  assign pad_o    = pad_oe_o & strobe_q;

  // R8: a restart leaves a cleared prescaler and a freshly loaded counter
  a_r8_restart_state: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ps_cnt == '0 && dc_cnt == $past(reload_i)));

  // R3: a disabled pad driver never drives a high level
  a_r3_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe_o |-> !pad_o);

  // R7: in internal mode the pad mirrors the strobe
  a_r7_pad_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe_o |-> (pad_o == update_o));

  // R9: in internal mode, only a counter expiry raises the strobe
  a_r9_timer_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_q) == SRC_TIMER && src_q == SRC_TIMER && update_o) |-> $past(int_fire));
endmodule

// File: tb/upd_strobe_gen_tb_top.sv
module upd_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_int_i = 1'b0;
  logic [1:0] prescale_i = 2'b00;
  logic [7:0] reload_i = 8'd0;
  logic       pad_i = 1'b0;
  logic       pad_o, pad_oe_o, update_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  upd_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode_int_i(mode_int_i), .prescale_i(prescale_i),
    .reload_i(reload_i), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .update_o(update_o)
  );

  // {code, reload}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'd3}, {2'b01, 8'd3}, {2'b10, 8'd2},
    {2'b11, 8'd1}, {2'b00, 8'd0}, {2'b11, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_pulse(output int n, output int pad_ok);
    n = 0;
    pad_ok = 1;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
      if (pad_o != update_o) pad_ok = 0;
    end while (!update_o && n < 2000);
  endtask

  function automatic int div_of(input logic [1:0] c);
    return 1 << c;
  endfunction

  initial begin
    int n, ok, per;
    #500_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, ok, per, d, seen;
    @(negedge clk);
    check("R1 update in reset", update_o, 0);
    check("R1 oe in reset", pad_oe_o, 0);
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R1 update after reset", update_o, 0);
    check("R1 pad after reset", pad_o, 0);
    check("R1 oe after reset", pad_oe_o, 0);

    // Table walk: R5, R6, R7, R8
    foreach (VEC[i]) begin
      mode_int_i = 1'b0;
      step(3);
      prescale_i = VEC[i][9:8];
      reload_i   = VEC[i][7:0];
      mode_int_i = 1'b1;
      d   = div_of(VEC[i][9:8]);
      per = (int'(VEC[i][7:0]) + 1) * d;
      wait_pulse(n, ok);
      check("R8 first interval", n, per + 1);
      check("R7 pad mirrors strobe", ok, 1);
      wait_pulse(n, ok);
      check("R5 R6 period", n, per);
      check("R7 pad during pulse", pad_o, 1);
      if (per > 1) begin
        step(1);
        check("R6 one-cycle pulse", update_o, 0);
        check("R7 pad low between", pad_o, 0);
      end
    end

    // R4: output enable timing on the switch back to external
    mode_int_i = 1'b0;
    check("R4 oe before edge", pad_oe_o, 1);
    step(1);
    check("R4 oe off", pad_oe_o, 0);
    mode_int_i = 1'b1;
    step(1);
    check("R4 oe on", pad_oe_o, 1);

    // R8 collision: code change part-way through an interval
    mode_int_i = 1'b0; step(3);
    prescale_i = 2'b00; reload_i = 8'd9; mode_int_i = 1'b1;
    wait_pulse(n, ok);
    step(5);
    prescale_i = 2'b01;
    wait_pulse(n, ok);
    check("R8 restart on code change", n, 21);

    // R9: pad toggles ignored in internal mode
    prescale_i = 2'b11; reload_i = 8'd20;
    step(1);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      pad_i = k[2];
      @(posedge clk); @(negedge clk);
      if (update_o) seen++;
    end
    check("R9 pad ignored", seen, 0);
    pad_i = 1'b0;

    // R2, R3: external mode
    mode_int_i = 1'b0;
    step(6);
    check("R3 oe low", pad_oe_o, 0);
    prescale_i = 2'b10;
    pad_i = 1'b1;
    wait_pulse(n, ok);
    check("R2 R3 edge latency", n, 3);
    check("R3 pad low", pad_o, 0);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (update_o) seen++;
    end
    check("R2 held high single pulse", seen, 0);
    pad_i = 1'b0; step(4);
    pad_i = 1'b1; step(1); pad_i = 1'b0;
    wait_pulse(n, ok);
    check("R2 short pulse edge", n, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule